// File: doc/BRIEF.md
# Heterogeneous Processing-Element Group

This block is a single group of four functional units within a loop-adaptive compute array. Every unit has a small private register file and an integer ALU. Only unit 1 of the group can reach the data memory, and only unit 2 holds a multiplier. In any cycle a unit may take an operand from four places: its own register file, the registered output of any of the four units (through a four-source, eight-destination crossbar that does not touch the register files), the same-index unit in the left or right neighbouring group, or an immediate.

Operation is fully static. Configuration words are loaded into a small loop schedule memory while the group is idle. A start pulse then steps through entries 0 to II-1 and wraps around until stop is raised. Each word holds the opcode, the operand routing and the writeback control for all four units, so the group contains no arbitration and no dynamic routing. When a multiply or memory opcode is placed on a unit that lacks that resource, the illegal-configuration flag is raised and that unit produces zero.

Top module: `pe_group`

## Requirements
- R1: While reset is low and in the first cycle after it is released, every lane of `fu_out` is zero, `running` is 0, `illegal_cfg` is 0 and `cfg_index` is 0.
- R2: A pulse on `cfg_we` writes `cfg_data` into schedule entry `cfg_addr` only while `running` is 0. A write while running has no effect on the schedule.
- R3: A start pulse while idle sets `running` and selects entry 0. Each later issue cycle advances `cfg_index` by one and wraps to 0 after entry II-1, where II is `ii_len` latched at start. An `ii_len` of 0 acts as 1.
- R4: A clock edge with `stop` high issues nothing and returns the group to idle. Whenever nothing issues, `fu_out` and the register files hold their values and `illegal_cfg` is 0.
- R5: The slice for unit k occupies bits [28k+27:28k] of a schedule word. Within the slice, [27:24] is the opcode, [23:21] the A source, [20:18] the B source, [17:15] the register-file read index for A, [14:12] the read index for B, [11] the writeback enable, [10:8] the writeback index and [7:0] the immediate.
- R6: Source codes are: 0 own register file, 1 to 4 the registered output of unit 0 to 3, 5 lane k of `left_in`, 6 lane k of `right_in`, 7 the immediate sign-extended to 32 bits.
- R7: Opcodes 1 ADD, 2 SUB (A-B), 3 AND, 4 OR, 5 XOR, 6 SHL, 7 logical SHR (shift amount B[4:0]) and 8 PASS A run on every unit. The result appears on the unit's lane of `fu_out` after the issuing edge.
- R8: Opcode 9 on unit 2 yields the low 32 bits of A*B after the issuing edge.
- R9: On unit 1, opcode 11 stores B at word A[7:0] of a 256-word memory and outputs B. Opcode 10 outputs the word at A[7:0] after the issuing edge.
- R10: Opcode 9 on any unit other than 2, or opcode 10 or 11 on any unit other than 1, drives that unit's lane to zero and sets `illegal_cfg` for the cycle after the issuing edge.
- R11: When the writeback enable is set, the unit's result is written into its own register file at the writeback index and can be read by a later entry.
- R12: Opcode 0 and the reserved opcodes 12 to 15 leave the unit's lane of `fu_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Schedule write strobe (honoured only while idle) |
| cfg_addr | input | 4 | Schedule entry to write |
| cfg_data | input | 112 | Schedule word, four 28-bit unit slices |
| ii_len | input | 5 | Loop length in entries, latched at start |
| start | input | 1 | Begin stepping the schedule |
| stop | input | 1 | End stepping; the edge carrying it issues nothing |
| left_in | input | 128 | Outputs of the left neighbour group, lane k for unit k |
| right_in | input | 128 | Outputs of the right neighbour group, lane k for unit k |
| fu_out | output | 128 | Registered unit results, lane k for unit k |
| running | output | 1 | Group is stepping the schedule |
| cfg_index | output | 4 | Schedule entry issued at the next edge |
| illegal_cfg | output | 1 | An issued entry put an unsupported opcode on a unit |

## Verification
The hardest situation to reach is a schedule wrap that has to depend on state from the previous pass. This covers a register value written by entry 0 and read by entry 2, a crossbar operand that a unit takes from its own previous result, a memory store on one pass followed by a load on the next, and a schedule write attempted in the middle of a run. The stimulus runs a three-entry loop twice with a write to entry 0 issued partway through and expects the second pass to match the first. A second run uses a zero loop length on a self-accumulating entry. If entry 1 were ever issued, its differing contents would show up in the outputs.

// File: rtl/pe_group_pkg.sv
package pe_group_pkg;
  localparam int DW      = 32;
  localparam int UNITS   = 4;
  localparam int RF_AW   = 3;
  localparam int RF_N    = 1 << RF_AW;
  localparam int OP_W    = 4;
  localparam int SRC_W   = 3;
  localparam int IMM_W   = 8;
  localparam int SLICE_W = OP_W + 2*SRC_W + 2*RF_AW + 1 + RF_AW + IMM_W;
  localparam int WORD_W  = UNITS * SLICE_W;
  localparam int SH_W    = $clog2(DW);
  localparam int MUL_UNIT = 2;
  localparam int MEM_UNIT = 1;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3,
    OP_OR  = 4'd4, OP_XOR = 4'd5, OP_SHL = 4'd6, OP_SHR = 4'd7,
    OP_PASS = 4'd8, OP_MUL = 4'd9, OP_LD = 4'd10, OP_ST = 4'd11
  } pe_op_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_RF = 3'd0, SRC_X0 = 3'd1, SRC_X1 = 3'd2, SRC_X2 = 3'd3,
    SRC_X3 = 3'd4, SRC_LEFT = 3'd5, SRC_RIGHT = 3'd6, SRC_IMM = 3'd7
  } pe_src_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [SRC_W-1:0] sa;
    logic [SRC_W-1:0] sb;
    logic [RF_AW-1:0] ra;
    logic [RF_AW-1:0] rb;
    logic             we;
    logic [RF_AW-1:0] wa;
    logic [IMM_W-1:0] imm;
  } unit_cfg_t;

  function automatic logic [DW-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(DW-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic is_alu(input logic [OP_W-1:0] op);
    return (op >= OP_ADD) && (op <= OP_PASS);
  endfunction

  function automatic logic is_mem(input logic [OP_W-1:0] op);
    return (op == OP_LD) || (op == OP_ST);
  endfunction

  function automatic logic [DW-1:0] alu_eval(input logic [OP_W-1:0] op,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    logic [DW-1:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_SHL:  r = a << b[SH_W-1:0];
      OP_SHR:  r = a >> b[SH_W-1:0];
      OP_PASS: r = a;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] mul_trunc(input logic [DW-1:0] a,
                                              input logic [DW-1:0] b);
    logic [2*DW-1:0] p;
    p = a * b;
    return p[DW-1:0];
  endfunction
endpackage

// File: rtl/pe_cfg_seq.sv
module pe_cfg_seq
  import pe_group_pkg::*;
#(
  parameter int CFG_DEPTH = 16,
  localparam int IDX_W = $clog2(CFG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic [IDX_W:0]    ii_len,
  input  logic              start,
  input  logic              stop,
  output logic              running,
  output logic              issue,
  output logic [IDX_W-1:0]  idx,
  output logic [IDX_W-1:0]  ii_last,
  output logic [WORD_W-1:0] word
);
  localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(CFG_DEPTH);

  logic [WORD_W-1:0] sched [CFG_DEPTH];
  logic [IDX_W:0]    lim;

  always_comb begin
    if (ii_len == '0)          lim = (IDX_W+1)'(1);
    else if (ii_len > DEPTH_V) lim = DEPTH_V;
    else                       lim = ii_len;
  end

  always_ff @(posedge clk) begin
    if (cfg_we && !running) sched[cfg_addr] <= cfg_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx     <= '0;
      ii_last <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        idx     <= '0;
        ii_last <= IDX_W'(lim - (IDX_W+1)'(1));
      end
    end else if (stop) begin
      running <= 1'b0;
      idx     <= '0;
    end else begin
      idx <= (idx == ii_last) ? '0 : idx + IDX_W'(1);
    end
  end

  assign issue = running && !stop;
  assign word  = sched[idx];
endmodule

// File: rtl/pe_operand_sel.sv
module pe_operand_sel
  import pe_group_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic [SRC_W-1:0]    src,
  input  logic [DW-1:0]       rf_val,
  input  logic [UNITS*DW-1:0] xbar,
  input  logic [DW-1:0]       left_val,
  input  logic [DW-1:0]       right_val,
  input  logic [IMM_W-1:0]    imm,
  output logic [DW-1:0]       val
);
  always_comb begin
    case (src)
      SRC_RF:    val = rf_val;
      SRC_X0:    val = xbar[0*DW +: DW];
      SRC_X1:    val = xbar[1*DW +: DW];
      SRC_X2:    val = xbar[2*DW +: DW];
      SRC_X3:    val = xbar[3*DW +: DW];
      SRC_LEFT:  val = left_val;
      SRC_RIGHT: val = right_val;
      default:   val = sext_imm(imm);
    endcase
  end
endmodule

// File: rtl/pe_fu.sv
module pe_fu
  import pe_group_pkg::*;
#(
  parameter int UNIT      = 0,
  parameter int MEM_DEPTH = 256,
  localparam int MA_W    = $clog2(MEM_DEPTH),
  localparam bit HAS_MUL = (UNIT == MUL_UNIT),
  localparam bit HAS_MEM = (UNIT == MEM_UNIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [OP_W-1:0]  op,
  input  logic [RF_AW-1:0] ra,
  input  logic [RF_AW-1:0] rb,
  input  logic             we,
  input  logic [RF_AW-1:0] wa,
  input  logic [DW-1:0]    op_a,
  input  logic [DW-1:0]    op_b,
  output logic [DW-1:0]    rd_a,
  output logic [DW-1:0]    rd_b,
  output logic [DW-1:0]    out,
  output logic             bad_op
);
  logic [DW-1:0] rf [RF_N];
  logic [DW-1:0] mul_val;
  logic [DW-1:0] mem_val;
  logic [DW-1:0] res;
  logic          takes;

  assign rd_a = rf[ra];
  assign rd_b = rf[rb];

  generate
    if (HAS_MUL) begin : g_mul
      assign mul_val = mul_trunc(op_a, op_b);
    end else begin : g_nomul
      assign mul_val = '0;
    end

    if (HAS_MEM) begin : g_mem
      logic [DW-1:0] dmem [MEM_DEPTH];
      assign mem_val = dmem[op_a[MA_W-1:0]];
      always_ff @(posedge clk) begin
        if (issue && op == OP_ST) dmem[op_a[MA_W-1:0]] <= op_b;
      end
    end else begin : g_nomem
      assign mem_val = '0;
    end
  endgenerate

  always_comb begin
    bad_op = ((op == OP_MUL) && !HAS_MUL) || (is_mem(op) && !HAS_MEM);
    takes  = 1'b1;
    res    = alu_eval(op, op_a, op_b);
    if (bad_op)             res = '0;
    else if (op == OP_MUL)  res = mul_val;
    else if (op == OP_LD)   res = mem_val;
    else if (op == OP_ST)   res = op_b;
    else if (!is_alu(op))   takes = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out <= '0;
      for (int i = 0; i < RF_N; i++) rf[i] <= '0;
    end else if (issue && takes) begin
      out <= res;
      if (we) rf[wa] <= res;
    end
  end
endmodule

// File: rtl/pe_group.sv
module pe_group
  import pe_group_pkg::*;
#(
  parameter int CFG_DEPTH = 16,
  parameter int MEM_DEPTH = 256,
  localparam int IDX_W = $clog2(CFG_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_addr,
  input  logic [WORD_W-1:0]   cfg_data,
  input  logic [IDX_W:0]      ii_len,
  input  logic                start,
  input  logic                stop,
  input  logic [UNITS*DW-1:0] left_in,
  input  logic [UNITS*DW-1:0] right_in,
  output logic [UNITS*DW-1:0] fu_out,
  output logic                running,
  output logic [IDX_W-1:0]    cfg_index,
  output logic                illegal_cfg
);
  logic              issue;
  logic [IDX_W-1:0]  ii_last;
  logic [WORD_W-1:0] word;
  logic [UNITS-1:0]  ill_vec;

  pe_cfg_seq #(.CFG_DEPTH(CFG_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .ii_len(ii_len), .start(start), .stop(stop),
    .running(running), .issue(issue), .idx(cfg_index),
    .ii_last(ii_last), .word(word)
  );

  generate
    for (genvar k = 0; k < UNITS; k++) begin : g_unit
      unit_cfg_t     ucfg;
      logic [DW-1:0] rd_a, rd_b, op_a, op_b;

      assign ucfg = unit_cfg_t'(word[k*SLICE_W +: SLICE_W]);

      pe_operand_sel #(.LANE(k)) u_sel_a (
        .src(ucfg.sa), .rf_val(rd_a), .xbar(fu_out),
        .left_val(left_in[k*DW +: DW]), .right_val(right_in[k*DW +: DW]),
        .imm(ucfg.imm), .val(op_a)
      );

      pe_operand_sel #(.LANE(k)) u_sel_b (
        .src(ucfg.sb), .rf_val(rd_b), .xbar(fu_out),
        .left_val(left_in[k*DW +: DW]), .right_val(right_in[k*DW +: DW]),
        .imm(ucfg.imm), .val(op_b)
      );

      pe_fu #(.UNIT(k), .MEM_DEPTH(MEM_DEPTH)) u_fu (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(ucfg.op),
        .ra(ucfg.ra), .rb(ucfg.rb), .we(ucfg.we), .wa(ucfg.wa),
        .op_a(op_a), .op_b(op_b), .rd_a(rd_a), .rd_b(rd_b),
        .out(fu_out[k*DW +: DW]), .bad_op(ill_vec[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) illegal_cfg <= 1'b0;
    else        illegal_cfg <= issue && (|ill_vec);
  end
endmodule

// File: rtl/pe_group_chk.sv
module pe_group_chk
  import pe_group_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                issue,
  input logic                running,
  input logic [IDX_W-1:0]    cfg_index,
  input logic [IDX_W-1:0]    ii_last,
  input logic [UNITS-1:0]    ill_vec,
  input logic                illegal_cfg,
  input logic [UNITS*DW-1:0] fu_out
);
  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (cfg_index == ii_last) |=> cfg_index == '0);

  // R3
  start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> cfg_index == '0);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(fu_out));

  // R4
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !illegal_cfg);

  // R10
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (|ill_vec) |=> illegal_cfg);

  generate
    for (genvar k = 0; k < UNITS; k++) begin : g_lane
      // R10
      illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue && ill_vec[k] |=> fu_out[k*DW +: DW] == '0);
    end
  endgenerate
endmodule

bind pe_group pe_group_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .running(running),
  .cfg_index(cfg_index), .ii_last(ii_last), .ill_vec(ill_vec),
  .illegal_cfg(illegal_cfg), .fu_out(fu_out)
);

// File: tb/pe_group_bench.sv
module pe_group_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_addr = '0;
  logic [111:0] cfg_data = '0;
  logic [4:0]   ii_len = '0;
  logic         start = 1'b0;
  logic         stop = 1'b0;
  logic [127:0] left_in, right_in;
  logic [127:0] fu_out;
  logic         running;
  logic [3:0]   cfg_index;
  logic         illegal_cfg;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [127:0] v;
    logic         ill;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  pe_group u_pe_group (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .ii_len(ii_len), .start(start), .stop(stop),
    .left_in(left_in), .right_in(right_in), .fu_out(fu_out),
    .running(running), .cfg_index(cfg_index), .illegal_cfg(illegal_cfg)
  );

  assign left_in  = {32'd40, 32'd30, 32'd20, 32'd10};
  assign right_in = {32'd4, 32'd3, 32'd2, 32'd1};

  function automatic logic [27:0] sl(input logic [3:0] op, input logic [2:0] sa,
                                     input logic [2:0] sb, input logic [2:0] ra,
                                     input logic [2:0] rb, input logic we,
                                     input logic [2:0] wa, input logic [7:0] imm);
    return {op, sa, sb, ra, rb, we, wa, imm};
  endfunction

  function automatic logic [127:0] lanes(input logic [31:0] a0, input logic [31:0] a1,
                                         input logic [31:0] a2, input logic [31:0] a3);
    return {a3, a2, a1, a0};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [127:0] v, input logic ill, input string tag);
    exp_t e;
    e.v = v; e.ill = ill; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic write_cfg(input logic [3:0] a, input logic [111:0] d);
    cfg_addr = a; cfg_data = d; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Monitor: an edge issues when running was high and stop low before it.
  bit pend = 1'b0;
  always @(negedge clk) begin
    if (pend) begin
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R3 unexpected issue actual=%h expected=none", fu_out);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " lanes"}, fu_out, e.v);
        check({e.tag, " R10 flag"}, {127'd0, illegal_cfg}, {127'd0, e.ill});
      end
    end
    pend = running && !stop;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  localparam logic [31:0] M60 = 32'hFFFF_FFC4;
  localparam logic [31:0] M5  = 32'hFFFF_FFFB;
  localparam logic [31:0] M75 = 32'hFFFF_FFB5;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 reset outputs", {fu_out, 3'b0, running, cfg_index, illegal_cfg}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {fu_out, 3'b0, running, cfg_index, illegal_cfg}, '0);
    @(posedge clk); #1;

    // R5 R6: three-entry schedule, unit k slice at bits 28k
    write_cfg(4'd0, {sl(4'd2, 3'd6, 3'd7, 0, 0, 0, 0, 8'd9),
                     sl(4'd9, 3'd5, 3'd7, 0, 0, 0, 0, 8'hFE),
                     sl(4'd11, 3'd7, 3'd6, 0, 0, 0, 0, 8'd7),
                     sl(4'd1, 3'd7, 3'd5, 0, 0, 1, 3'd1, 8'd5)});
    write_cfg(4'd1, {sl(4'd5, 3'd2, 3'd0, 0, 0, 0, 0, 8'd0),
                     sl(4'd9, 3'd1, 3'd4, 0, 0, 0, 0, 8'd0),
                     sl(4'd10, 3'd7, 3'd0, 0, 0, 0, 0, 8'd7),
                     sl(4'd8, 3'd3, 3'd0, 0, 0, 0, 0, 8'd0)});
    write_cfg(4'd2, {sl(4'd6, 3'd4, 3'd7, 0, 0, 0, 0, 8'd4),
                     sl(4'd10, 3'd7, 3'd7, 0, 0, 0, 0, 8'd3),
                     sl(4'd9, 3'd7, 3'd7, 0, 0, 0, 0, 8'd3),
                     sl(4'd1, 3'd0, 3'd7, 3'd1, 0, 0, 0, 8'd1)});
    check("R2 idle writes leave group idle", {31'd0, running}, 32'd0);

    ii_len = 5'd3;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R3 start selects entry 0", {27'd0, running, cfg_index}, {27'd0, 1'b1, 4'd0});
    for (int pass = 0; pass < 2; pass++) begin
      // R6 R7 R8 R9: entry 0
      push(lanes(32'd15, 32'd2, M60, M5), 1'b0, "R7 R8 R9 entry0");
      if (pass == 0) begin
        cfg_addr = 4'd0; cfg_data = '0; cfg_we = 1'b1;  // R2: ignored while running
      end
      @(posedge clk); #1;
      cfg_we = 1'b0;
      // R6 R8 R9: crossbar operands, load of stored word
      push(lanes(M60, 32'd2, M75, 32'd2), 1'b0, "R6 R8 R9 entry1");
      @(posedge clk); #1;
      // R10 R11: illegal opcodes on units 1 and 2, register readback on unit 0
      push(lanes(32'd16, 32'd0, 32'd0, 32'd32), 1'b1, pass == 0 ? "R10 R11 entry2" : "R2 R3 wrapped entry2");
      @(posedge clk); #1;
    end
    stop = 1'b1;
    @(posedge clk); #1;
    stop = 1'b0;
    check("R4 stop returns idle", {27'd0, running, cfg_index}, '0);
    repeat (3) @(posedge clk);
    #1;
    check("R4 outputs hold while idle", fu_out, lanes(32'd16, 32'd0, 32'd0, 32'd32));
    check("R4 flag low while idle", {31'd0, illegal_cfg}, 32'd0);

    // R3 R12: zero loop length acts as one; entry 1 must never issue
    write_cfg(4'd0, {sl(4'd7, 3'd4, 3'd7, 0, 0, 0, 0, 8'd1),
                     sl(4'd4, 3'd5, 3'd7, 0, 0, 0, 0, 8'd1),
                     sl(4'd15, 3'd7, 3'd7, 0, 0, 0, 0, 8'd9),
                     sl(4'd1, 3'd1, 3'd7, 0, 0, 0, 0, 8'd1)});
    write_cfg(4'd1, {4{sl(4'd8, 3'd7, 3'd7, 0, 0, 0, 0, 8'd99)}});
    ii_len = 5'd0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    push(lanes(32'd17, 32'd0, 32'd31, 32'd16), 1'b0, "R3 R12 len0 issue1");
    @(posedge clk); #1;
    check("R3 len0 stays on entry 0", {28'd0, cfg_index}, 32'd0);
    push(lanes(32'd18, 32'd0, 32'd31, 32'd8), 1'b0, "R3 R12 len0 issue2");
    @(posedge clk); #1;
    push(lanes(32'd19, 32'd0, 32'd31, 32'd4), 1'b0, "R3 R7 len0 issue3");
    @(posedge clk); #1;
    stop = 1'b1;
    @(posedge clk); #1;
    stop = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R3 scoreboard drained", {32'(q.size())}, 32'd0);
    report();
  end
endmodule